// File: doc/BRIEF.md
# Packed-Byte Sum of Absolute Differences Accumulator

This block computes a running sum of absolute differences between two streams of 8-bit pixels, for block-matching motion estimation. In each step it takes two 32-bit words, a reference word and a candidate word. Each word holds four unsigned pixels. For every byte lane the block forms the absolute difference from two unsigned saturating subtractions taken in opposite directions. One of the two is always zero, so their sum is the magnitude.

The four lane differences are then folded. Lanes 0 and 1 are added into the low 16-bit half, and lanes 2 and 3 into the high 16-bit half. The two halves are added to give the SAD of that word pair, which goes into a 16-bit running total. A search engine outside this block fetches the pixel words, pulses `sad_clear` at the start of each candidate block, and reads `sad_total` after the last word pair.

The only register stage is the accumulator. A word pair presented with `pix_valid` high is therefore reflected on `sad_total` right after the next rising clock edge.

Top module: `packed_sad_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the total is set to 0, and `sad_total` reads 0 after that edge.
- R2: Pixel k of each word occupies bits [8k+7:8k] (k = 0..3), and each lane contributes |ref - cur| to the step SAD, so exchanging the two words gives the same result.
- R3: Each lane difference is built from two unsigned subtractions that clamp negative results to 0, and in every lane at least one of the two is 0.
- R4: Lanes 0 and 1 are summed into the low 16-bit half and lanes 2 and 3 into the high half. The step SAD is the sum of the two halves and never exceeds 1020.
- R5: With `pix_valid` high and `sad_clear` low at a rising edge, `sad_total` becomes its previous value plus the step SAD after that edge.
- R6: With `pix_valid` and `sad_clear` both low at a rising edge, `sad_total` keeps its value.
- R7: With `sad_clear` high at a rising edge, `sad_total` becomes 0 after that edge, whether or not `pix_valid` is high in that cycle.
- R8: The total is 16 bits wide and wraps modulo 65536 when an addition overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sad_clear | input | 1 | Zeroes the running total; takes priority over pix_valid |
| pix_valid | input | 1 | Qualifies the two pixel words for accumulation |
| ref_word | input | 32 | Four packed unsigned reference pixels |
| cur_word | input | 32 | Four packed unsigned candidate pixels |
| sad_total | output | 16 | Running SAD total |

## Verification
The assertions check four things on every cycle:
- at least one saturating term in each lane is zero;
- the folded step SAD stays within 1020;
- the total holds when idle and is zero after a clear;
- the total moves by exactly the step SAD after a valid word pair.

Only the bench's scenarios can show the rest: that the byte lanes line up with the right pixels, that swapping the words leaves the sum unchanged, the exact numeric results against an independent model, clear winning over valid, and wraparound past 65535.

// File: rtl/sad_pkg.sv
// Package: shared widths for the packed SAD datapath.
// Assumes an even lane count so lanes pair up cleanly.
package sad_pkg;
    localparam int PIX_W  = 8;
    localparam int LANES  = 4;
    localparam int HALF_W = 16;
    localparam int ACC_W  = 16;
    localparam int STEP_W = PIX_W + $clog2(LANES);
endpackage

// File: rtl/sad_lane_absdiff.sv
// Module: one byte lane of the absolute-difference stage.
// Forms sat(a-b) and sat(b-a), each clamped at zero, and adds them.
// Assumes unsigned pixels; purely combinational.
module sad_lane_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    output logic [PIX_W-1:0] sat_ab,
    output logic [PIX_W-1:0] sat_ba,
    output logic [PIX_W-1:0] abs_diff
);
    logic [PIX_W:0] raw_ab;
    logic [PIX_W:0] raw_ba;

    // Saturating subtractions: the borrow bit forces the result to zero.
    always_comb begin
        raw_ab   = {1'b0, pix_a} - {1'b0, pix_b};
        raw_ba   = {1'b0, pix_b} - {1'b0, pix_a};
        sat_ab   = raw_ab[PIX_W] ? '0 : raw_ab[PIX_W-1:0];
        sat_ba   = raw_ba[PIX_W] ? '0 : raw_ba[PIX_W-1:0];
        abs_diff = sat_ab | sat_ba;
    end
endmodule

// File: rtl/sad_pair_fold.sv
// Module: folds lane differences into packed halves and sums them.
// Adjacent lanes (0,1), (2,3), ... form pairs. Each pair sum is
// widened into its own HALF_W slot, and the slots are added to give
// the step SAD. Assumes LANES is even; purely combinational.
module sad_pair_fold #(
    parameter int PIX_W  = 8,
    parameter int LANES  = 4,
    parameter int HALF_W = 16,
    parameter int STEP_W = 10
) (
    input  logic [LANES*PIX_W-1:0]      lane_diff,
    output logic [(LANES/2)*HALF_W-1:0] packed_halves,
    output logic [STEP_W-1:0]           step_sad
);
    localparam int NPAIR = LANES / 2;

    genvar p;
    generate
        for (p = 0; p < NPAIR; p++) begin : g_pair
            logic [PIX_W:0] pair_sum;
            // Pair add: low lane plus high lane of this pair.
            always_comb begin
                pair_sum = {1'b0, lane_diff[(2*p)*PIX_W +: PIX_W]}
                         + {1'b0, lane_diff[(2*p+1)*PIX_W +: PIX_W]};
            end
            assign packed_halves[p*HALF_W +: HALF_W] = HALF_W'(pair_sum);
        end
    endgenerate

    // Final reduction: sum the widened halves.
    always_comb begin
        step_sad = '0;
        for (int i = 0; i < NPAIR; i++) begin
            step_sad = step_sad + STEP_W'(packed_halves[i*HALF_W +: HALF_W]);
        end
    end
endmodule

// File: rtl/sad_accum.sv
// Module: running SAD total, the single register stage.
// Clear has priority over a valid step; the sum wraps at ACC_W bits.
module sad_accum #(
    parameter int STEP_W = 10,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step_valid,
    input  logic [STEP_W-1:0] step_sad,
    output logic [ACC_W-1:0]  total
);
    // Accumulator update: reset, clear, add, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          total <= '0;
        else if (clr)        total <= '0;
        else if (step_valid) total <= total + ACC_W'(step_sad);
    end

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step_valid) |=> $stable(total));
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total == '0));
    assert_add_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step_valid) |=> (total == ACC_W'($past(total) + ACC_W'($past(step_sad)))));
endmodule

// File: rtl/packed_sad_unit.sv
// Module: top of the packed-byte SAD datapath.
// Lanes -> pair fold -> accumulator. Word inputs are combinational up
// to the accumulator, so results appear one edge after a valid pair.
module packed_sad_unit
    import sad_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sad_clear,
    input  logic                   pix_valid,
    input  logic [LANES*PIX_W-1:0] ref_word,
    input  logic [LANES*PIX_W-1:0] cur_word,
    output logic [ACC_W-1:0]       sad_total
);
    localparam int NPAIR    = LANES / 2;
    localparam int STEP_MAX = LANES * ((1 << PIX_W) - 1);

    logic [LANES*PIX_W-1:0]  lane_diff;
    logic [LANES*PIX_W-1:0]  sat_ab_v;
    logic [LANES*PIX_W-1:0]  sat_ba_v;
    logic [NPAIR*HALF_W-1:0] halves;
    logic [STEP_W-1:0]       step_sad;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            sad_lane_absdiff #(.PIX_W(PIX_W)) u_lane (
                .pix_a    (ref_word[k*PIX_W +: PIX_W]),
                .pix_b    (cur_word[k*PIX_W +: PIX_W]),
                .sat_ab   (sat_ab_v[k*PIX_W +: PIX_W]),
                .sat_ba   (sat_ba_v[k*PIX_W +: PIX_W]),
                .abs_diff (lane_diff[k*PIX_W +: PIX_W])
            );
            assert_one_side_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (sat_ab_v[k*PIX_W +: PIX_W] == '0) || (sat_ba_v[k*PIX_W +: PIX_W] == '0));
        end
    endgenerate

    sad_pair_fold #(
        .PIX_W(PIX_W), .LANES(LANES), .HALF_W(HALF_W), .STEP_W(STEP_W)
    ) u_fold (
        .lane_diff     (lane_diff),
        .packed_halves (halves),
        .step_sad      (step_sad)
    );

    assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(step_sad) <= STEP_MAX);

    sad_accum #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sad_clear),
        .step_valid (pix_valid),
        .step_sad   (step_sad),
        .total      (sad_total)
    );
endmodule

// File: tb/tb_packed_sad_unit.sv
// Bench: directed corners plus seeded random word pairs, all checked
// against a reference model kept in the bench.
module tb_packed_sad_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sad_clear = 1'b0;
    logic        pix_valid = 1'b0;
    logic [31:0] ref_word = '0;
    logic [31:0] cur_word = '0;
    logic [15:0] sad_total;

    int total_checks = 0;
    int bad_checks   = 0;
    int model        = 0;
    bit done         = 1'b0;

    always #2.5 clk = ~clk;

    packed_sad_unit dut (
        .clk(clk), .rst_n(rst_n), .sad_clear(sad_clear), .pix_valid(pix_valid),
        .ref_word(ref_word), .cur_word(cur_word), .sad_total(sad_total)
    );

    // Reference SAD of one word pair, lane by lane.
    function automatic int word_sad(input logic [31:0] a, input logic [31:0] b);
        int s = 0;
        for (int k = 0; k < 4; k++) begin
            int x = a[k*8 +: 8];
            int y = b[k*8 +: 8];
            s += (x > y) ? x - y : y - x;
        end
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge and update the model.
    // The output is then sampled at the following falling edge.
    task automatic step(input bit v, input bit c, input logic [31:0] a,
                        input logic [31:0] b);
        @(negedge clk);
        pix_valid = v; sad_clear = c; ref_word = a; cur_word = b;
        if (c)      model = 0;
        else if (v) model = (model + word_sad(a, b)) % 65536;
        @(negedge clk);
        pix_valid = 1'b0; sad_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad_checks++;
            total_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5ad1;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset", int'(sad_total), 0);
        rst_n = 1'b1;

        // R2: lane 2 alone (bits [23:16]) differs, so the step is that lane's difference.
        step(1, 0, 32'h0050_0000, 32'h0010_0000);
        check("R2 lane position", int'(sad_total), model);
        check("R2 lane value", int'(sad_total), 64);

        // R2/R3: swapped words give the same sum.
        step(1, 1, 0, 0);
        step(1, 0, 32'h10F0_3380, 32'hF010_8033);
        check("R2 order a", int'(sad_total), model);
        step(1, 1, 0, 0);
        step(1, 0, 32'hF010_8033, 32'h10F0_3380);
        check("R3 order b", int'(sad_total), model);

        // R4: largest step SAD.
        step(1, 1, 0, 0);
        step(1, 0, 32'hFFFF_FFFF, 32'h0000_0000);
        check("R4 max step", int'(sad_total), 1020);

        // R6: idle cycles with varying words.
        step(0, 0, 32'h1234_5678, 32'h8765_4321);
        check("R6 hold", int'(sad_total), 1020);

        // R7: clear wins over valid.
        step(1, 1, 32'hFFFF_FFFF, 0);
        check("R7 clear priority", int'(sad_total), 0);

        // R5: identical words add nothing.
        step(1, 0, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
        check("R5 equal words", int'(sad_total), 0);

        // R8: wrap past 65535.
        for (int i = 0; i < 70; i++) step(1, 0, 32'hFFFF_FFFF, 0);
        check("R8 wrap", int'(sad_total), (70 * 1020) % 65536);
        check("R8 wrap model", int'(sad_total), model);

        // Random mix of valid, idle and clear.
        for (int i = 0; i < 400; i++) begin
            int r = $urandom % 16;
            step(r < 12, r == 15, $urandom, $urandom);
            check("R5 random", int'(sad_total), model);
        end

        // R1: reset in mid-run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", int'(sad_total), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule